// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block produces the gain coefficient for an audio path so that muting and unmuting happen as a smooth fade rather than a step. The audio multiplier sits outside the block. A mute request comes from an active-low external pin or from a register enable bit. When a request arrives, the 16-bit gain falls from unity to zero along an S-shaped curve. The curve changes slowly near both ends and fastest in the middle. When the request goes away, the gain climbs back the same way. One of four ramp lengths is picked when each ramp starts.

A status flag is high for the whole time the path is not fully open. The block also drives the hard mute of the stereo decoder. That mute comes on once the fade has fully reached zero, but only if the decoder is the selected source and the coupling option is on. On unmute it is dropped at once, while the audio fades back in. A direct decoder mute bit overrides all of this. Every output is registered, so it follows the inputs sampled on the previous clock edge.

Top module: `smute_ramp`

## Requirements
- R1: After reset, `gain` is 0xFFFF (unity), `busy` is 0 and `dec_mute` is 0.
- R2: The mute request is (`mute_pin_n` == 0) OR (`mute_reg_en` == 1). From the open state, either source starts a mute ramp, and `busy` is 1 one clock after the request is sampled.
- R3: `ramp_sel` encodes the ramp length: 0 → DUR0, 1 → DUR1, 2 → DUR2, 3 → DUR3 clock cycles. The level steps once every DIV = DURk / N_STEPS cycles, so a ramp ends N_STEPS × DIV cycles after it starts.
- R4: The gain is an S-curve of the level k (0..N_STEPS, N = N_STEPS): gain = floor(65535 × (3·N·k² − 2·k³) / N³). At k = N/2 this gives 32767.
- R5: During a mute ramp the gain never rises, and it ends at 0. During an unmute ramp the gain never falls, and it ends at 0xFFFF.
- R6: A ramp that has started always runs to completion. Changes to the request or to `ramp_sel` while it runs have no effect on its direction or length.
- R7: When a ramp completes and the opposite request is present, a new ramp starts on the next clock.
- R8: `busy` is 1 from the first cycle of a mute ramp until the gain is back at unity. It is 0 only when the path is fully open.
- R9: `dec_mute` is asserted while fully muted (gain 0) only when `couple_en` = 1 and `src_sel` equals DEC_SRC (default 0). Otherwise the fade alone does not assert it.
- R10: On unmute, `dec_mute` falls in the same cycle that the unmute ramp starts, while the gain is still 0.
- R11: `dec_force` = 1 asserts `dec_mute` one clock later, whatever the ramp state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_pin_n | input | 1 | External mute request, active low |
| mute_reg_en | input | 1 | Register mute request, active high |
| ramp_sel | input | 2 | Ramp length select, latched at ramp start |
| couple_en | input | 1 | Lets a full soft mute drive the decoder mute |
| src_sel | input | SRC_W | Selected audio source |
| dec_force | input | 1 | Direct decoder mute |
| gain | output | GAIN_W | Gain coefficient, 0xFFFF = unity |
| busy | output | 1 | High unless fully unmuted |
| dec_mute | output | 1 | Decoder hard mute |

## Verification
On every cycle the assertions check the following:
- The gain is unity in the open state and zero in the muted state.
- The gain moves in one direction only while a ramp runs.
- A running ramp never reverses.
- A low `busy` implies unity gain.
- A coupled decoder mute implies zero gain.
- The level steps are never closer together than the divider allows.

The exact ramp lengths for each `ramp_sel` value, the curve value at mid-level, and the one-cycle restart after a ramp ends with an opposite request can only be shown by the bench's scenarios. The same holds for ignoring changes in mid-ramp and for the timing of the decoder mute release. There, a behavioural model is compared against the outputs on every clock.

// File: rtl/smute_pkg.sv
package smute_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_FALL = 2'd1,
        ST_SHUT = 2'd2,
        ST_RISE = 2'd3
    } smute_state_e;
endpackage

// File: rtl/smute_pace.sv
// Step pacer: emits one tick every DIV cycles while a ramp runs.
// DIV comes from the length select latched at ramp start.
module smute_pace #(
    parameter int N_STEPS = 64,
    parameter int DUR0    = 60000,
    parameter int DUR1    = 120000,
    parameter int DUR2    = 5050000,
    parameter int DUR3    = 40500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int D0 = (DUR0 / N_STEPS > 0) ? DUR0 / N_STEPS : 1;
    localparam int D1 = (DUR1 / N_STEPS > 0) ? DUR1 / N_STEPS : 1;
    localparam int D2 = (DUR2 / N_STEPS > 0) ? DUR2 / N_STEPS : 1;
    localparam int D3 = (DUR3 / N_STEPS > 0) ? DUR3 / N_STEPS : 1;
    localparam int DA = (D0 > D1) ? D0 : D1;
    localparam int DB = (D2 > D3) ? D2 : D3;
    localparam int DMAX = (DA > DB) ? DA : DB;
    localparam int CW = $clog2(DMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    sel;
    } pace_t;

    pace_t cur_q, nx_d;

    function automatic logic [CW-1:0] div_of(input logic [1:0] s);
        case (s)
            2'd0:    div_of = CW'(D0);
            2'd1:    div_of = CW'(D1);
            2'd2:    div_of = CW'(D2);
            default: div_of = CW'(D3);
        endcase
    endfunction

    always_comb begin
        nx_d = cur_q;
        tick = 1'b0;
        if (restart) begin
            nx_d.sel = sel;
            nx_d.cnt = div_of(sel) - CW'(1);
        end else if (run) begin
            if (cur_q.cnt == '0) begin
                tick     = 1'b1;
                nx_d.cnt = div_of(cur_q.sel) - CW'(1);
            end else begin
                nx_d.cnt = cur_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nx_d;
        end
    end

    // R3: steps are spaced by the divider, never back to back when DIV > 1
    p_step_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_of(cur_q.sel) != CW'(1)) |=> !tick);
endmodule

// File: rtl/smute_shape.sv
// S-curve: gain = UNITY * (3*N*k^2 - 2*k^3) / N^3, N a power of two.
module smute_shape #(
    parameter int N_STEPS = 64,
    parameter int GAIN_W  = 16,
    parameter int LW      = 7
) (
    input  logic [LW-1:0]     lvl,
    output logic [GAIN_W-1:0] gain
);
    localparam int LOGN = $clog2(N_STEPS);
    localparam int PW   = 3 * LOGN + GAIN_W + 4;
    localparam logic [GAIN_W-1:0] UNITY = '1;

    logic [PW-1:0] k, poly, prod;

    always_comb begin
        k    = PW'(lvl);
        poly = (PW'(3 * N_STEPS) * k * k) - (PW'(2) * k * k * k);
        prod = poly * PW'(UNITY);
        gain = GAIN_W'(prod >> (3 * LOGN));
    end
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
    import smute_pkg::*;
#(
    parameter int N_STEPS = 64,
    parameter int GAIN_W  = 16,
    parameter int SRC_W   = 2,
    parameter int DEC_SRC = 0,
    // ramp lengths in clock cycles (defaults: 0.48, 0.96, 40.4, 324 ms at 125 MHz)
    parameter int DUR0    = 60000,
    parameter int DUR1    = 120000,
    parameter int DUR2    = 5050000,
    parameter int DUR3    = 40500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_pin_n,
    input  logic              mute_reg_en,
    input  logic [1:0]        ramp_sel,
    input  logic              couple_en,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic              dec_force,
    output logic [GAIN_W-1:0] gain,
    output logic              busy,
    output logic              dec_mute
);
    localparam int LW = $clog2(N_STEPS) + 1;
    localparam logic [LW-1:0] LVL_FULL = LW'(N_STEPS);
    localparam logic [GAIN_W-1:0] UNITY = '1;

    typedef struct packed {
        smute_state_e st;
        logic [LW-1:0] lvl;
        logic          busy;
        logic          dec;
    } core_t;

    core_t cur_q, nx_d;
    logic [GAIN_W-1:0] gain_q, shaped;
    logic req, restart, run, tick;

    assign req     = ~mute_pin_n | mute_reg_en;
    assign restart = ((cur_q.st == ST_OPEN) && req) || ((cur_q.st == ST_SHUT) && !req);
    assign run     = (cur_q.st == ST_FALL) || (cur_q.st == ST_RISE);

    smute_pace #(
        .N_STEPS(N_STEPS), .DUR0(DUR0), .DUR1(DUR1), .DUR2(DUR2), .DUR3(DUR3)
    ) u_pace (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .sel(ramp_sel), .tick(tick)
    );

    always_comb begin
        nx_d = cur_q;
        case (cur_q.st)
            ST_OPEN: if (req) nx_d.st = ST_FALL;
            ST_FALL: if (tick) begin
                nx_d.lvl = cur_q.lvl - LW'(1);
                if (cur_q.lvl == LW'(1)) nx_d.st = ST_SHUT;
            end
            ST_SHUT: if (!req) nx_d.st = ST_RISE;
            ST_RISE: if (tick) begin
                nx_d.lvl = cur_q.lvl + LW'(1);
                if (cur_q.lvl == LVL_FULL - LW'(1)) nx_d.st = ST_OPEN;
            end
            default: nx_d.st = ST_OPEN;
        endcase
        nx_d.busy = (nx_d.st != ST_OPEN);
        nx_d.dec  = dec_force ||
                    (couple_en && (src_sel == SRC_W'(DEC_SRC)) && (nx_d.st == ST_SHUT));
    end

    smute_shape #(.N_STEPS(N_STEPS), .GAIN_W(GAIN_W), .LW(LW)) u_shape (
        .lvl(nx_d.lvl), .gain(shaped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_OPEN;
            cur_q.lvl  <= LVL_FULL;
            cur_q.busy <= 1'b0;
            cur_q.dec  <= 1'b0;
            gain_q     <= UNITY;
        end else begin
            cur_q  <= nx_d;
            gain_q <= shaped;
        end
    end

    assign gain     = gain_q;
    assign busy     = cur_q.busy;
    assign dec_mute = cur_q.dec;

    p_open_unity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_OPEN) |-> (gain_q == UNITY));
    p_shut_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SHUT) |-> (gain_q == '0));
    p_fall_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FALL) |=> (gain_q <= $past(gain_q)));
    p_rise_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RISE) |=> (gain_q >= $past(gain_q)));
    p_fall_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FALL) |=> (cur_q.st == ST_FALL || cur_q.st == ST_SHUT));
    p_rise_no_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RISE) |=> (cur_q.st == ST_RISE || cur_q.st == ST_OPEN));
    p_idle_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.busy |-> (gain_q == UNITY));
    p_dec_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.dec && !$past(dec_force)) |-> (gain_q == '0));
    p_dec_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_q.st) == ST_SHUT && cur_q.st == ST_RISE && !$past(dec_force))
        |-> !cur_q.dec);
    p_force_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_force |=> cur_q.dec);
endmodule

// File: tb/smute_ramp_tb.sv
`timescale 1ns/1ps
module smute_ramp_tb;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mute_pin_n = 1'b1, mute_reg_en = 1'b0, couple_en = 1'b1, dec_force = 1'b0;
    logic [1:0] ramp_sel = 2'd0;
    logic [1:0] src_sel = 2'd0;
    logic [15:0] gain;
    logic busy, dec_mute;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    smute_ramp #(.DUR0(128), .DUR1(192), .DUR2(320), .DUR3(512)) u_dut (
        .clk(clk), .rst_n(rst_n), .mute_pin_n(mute_pin_n), .mute_reg_en(mute_reg_en),
        .ramp_sel(ramp_sel), .couple_en(couple_en), .src_sel(src_sel),
        .dec_force(dec_force), .gain(gain), .busy(busy), .dec_mute(dec_mute)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic int div_for(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 3;
            2'd2: return 5;
            default: return 8;
        endcase
    endfunction

    function automatic int s_curve(input int k);
        longint num;
        num = longint'(3 * N) * k * k - longint'(2) * k * k * k;
        return int'((num * 65535) / (longint'(N) * N * N));
    endfunction

    int m_mode, m_lvl, m_t, m_div;  // mode: 0 open, 1 falling, 2 muted, 3 rising
    logic [15:0] m_gain;
    bit m_busy, m_dec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_lvl = N; m_t = 0; m_div = 2;
            m_gain = 16'hFFFF; m_busy = 0; m_dec = 0;
        end else begin
            bit want;
            want = !mute_pin_n || mute_reg_en;
            if (m_mode == 0 && want) begin
                m_mode = 1; m_t = 0; m_div = div_for(ramp_sel);
            end else if (m_mode == 2 && !want) begin
                m_mode = 3; m_t = 0; m_div = div_for(ramp_sel);
            end else if (m_mode == 1 || m_mode == 3) begin
                m_t++;
                m_lvl = (m_mode == 1) ? N - m_t / m_div : m_t / m_div;
                if (m_t == N * m_div) m_mode = (m_mode == 1) ? 2 : 0;
            end
            m_gain = 16'(s_curve(m_lvl));
            m_busy = (m_mode != 0);
            m_dec  = dec_force || (couple_en && src_sel == 2'd0 && m_mode == 2);
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R4 gain vs model", 32'(gain), 32'(m_gain));
            chk("R8 busy vs model", 32'(busy), 32'(m_busy));
            chk("R9 dec_mute vs model", 32'(dec_mute), 32'(m_dec));
        end
    end

    task automatic wait_gain(input logic [15:0] v, inout int n);
        while (gain !== v && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk("R1 reset gain", 32'(gain), 32'hFFFF);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset dec_mute", 32'(dec_mute), 0);

        // pin mute, length select 0 (DIV 2)
        mute_pin_n = 1'b0;
        @(negedge clk);
        chk("R2 pin starts ramp", 32'(busy), 1);
        n = 1;
        wait_gain(16'h0000, n);
        chk("R3 sel0 ramp length", 32'(n), 32'(N * 2 + 1));
        chk("R5 mute ends at zero", 32'(gain), 0);
        chk("R9 coupled dec mute", 32'(dec_mute), 1);

        // unmute with select 1 (DIV 3)
        ramp_sel = 2'd1;
        mute_pin_n = 1'b1;
        @(negedge clk);
        chk("R10 dec mute released", 32'(dec_mute), 0);
        chk("R10 gain still zero", 32'(gain), 0);
        chk("R8 busy during unmute", 32'(busy), 1);
        repeat (N / 2 * 3) @(negedge clk);
        chk("R4 mid curve value", 32'(gain), 32'd32767);
        // mid-ramp: new request and select change must not matter
        mute_reg_en = 1'b1;
        ramp_sel = 2'd3;
        src_sel = 2'd1;
        n = N / 2 * 3;
        wait_gain(16'hFFFF, n);
        chk("R6 unmute ran full length", 32'(n), 32'(N * 3));
        chk("R5 unmute ends at unity", 32'(gain), 32'hFFFF);
        chk("R8 busy low at end of unmute", 32'(busy), 0);
        @(negedge clk);
        chk("R7 pending request restarts", 32'(busy), 1);
        n = 0;
        wait_gain(16'h0000, n);
        chk("R3 sel3 ramp length", 32'(n), 32'(N * 8));
        chk("R9 no dec mute for other source", 32'(dec_mute), 0);
        dec_force = 1'b1;
        @(negedge clk);
        chk("R11 force while muted", 32'(dec_mute), 1);
        dec_force = 1'b0;
        src_sel = 2'd0;
        @(negedge clk);
        chk("R9 dec mute with decoder source", 32'(dec_mute), 1);
        couple_en = 1'b0;
        @(negedge clk);
        chk("R9 coupling off", 32'(dec_mute), 0);

        // register release, select 2 (DIV 5)
        ramp_sel = 2'd2;
        mute_reg_en = 1'b0;
        @(negedge clk);
        n = 1;
        wait_gain(16'hFFFF, n);
        chk("R3 sel2 ramp length", 32'(n), 32'(N * 5 + 1));
        dec_force = 1'b1;
        @(negedge clk);
        chk("R11 force while open", 32'(dec_mute), 1);
        chk("R11 gain unaffected", 32'(gain), 32'hFFFF);
        dec_force = 1'b0;
        @(negedge clk);
        mute_reg_en = 1'b1;
        @(negedge clk);
        chk("R2 register bit starts ramp", 32'(busy), 1);
        repeat (5) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule